// File: doc/BRIEF.md
# Host Command Port with Address-Gate Output Register

This block is the host-facing side of a legacy keyboard-controller style peripheral. The host talks to it through two byte-wide I/O addresses: a command/status address (0x64 by default) and a data address (0x60 by default). Every byte the host writes lands in a one-byte input buffer. The block holds it there for a programmable number of clock cycles and then processes it. Bytes travelling back to the host pass through a one-byte output buffer. Two status flags report whether each buffer is full.

A small command engine maintains an 8-bit general output register. The host can read that register back through the output buffer. It can also arm a one-shot write so that the next data byte replaces the register. Bit 1 of the register drives the enable of the address-bit-20 gate. Two further commands turn a keyboard-interface enable flag off and on. The processing delay holds the input-buffer-full flag long enough for polling firmware to see it. A write that arrives while the buffer is still busy is lost.

Top module: `kbc_cmd_port`

## Requirements
- R1: After reset the output register holds 0xDD, the gate output is 0, the keyboard-interface enable is 1, and both buffer-full flags are clear.
- R2: A read of the command/status address returns the status byte: bit 1 is input-buffer-full, bit 0 is output-buffer-full, and bits 7..2 are 0.
- R3: A write to either port address while input-buffer-full is clear sets input-buffer-full. With a delay setting of D, the flag stays set for D+1 clock cycles after the write edge and then clears when the byte is processed.
- R4: A write to either port address while input-buffer-full is set is dropped and has no effect.
- R5: Command 0xD0 copies the output register into the output buffer and sets output-buffer-full.
- R6: A read of the data address returns the output buffer contents and clears output-buffer-full on that clock edge.
- R7: Command 0xD1 arms a pending write. The next processed data byte is stored in the output register and disarms it. The gate output always equals bit 1 of the output register.
- R8: A data byte processed while no write is pending leaves the output register unchanged.
- R9: Command 0xAD clears the keyboard-interface enable and command 0xAE sets it.
- R10: Any processed command other than 0xD1 disarms a pending write.
- R11: An unrecognised command byte is consumed (input-buffer-full sets and clears as in R3) and changes neither the output register, the interface enable nor output-buffer-full.
- R12: Reads and writes to addresses other than the two port addresses are ignored, and such reads return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| io_addr | input | 8 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, one byte per cycle |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data; combinational while io_rd is high, 0x00 otherwise |
| delay_cfg | input | 8 | Processing delay in cycles beyond the first |
| out_port | output | 8 | General output register |
| a20_gate | output | 1 | Address-bit-20 gate enable (out_port bit 1) |
| kbd_enable | output | 1 | Keyboard-interface enable flag |

## Verification
A wrong pending-write flag shows up as a data byte that either fails to reach out_port or lands there when it should not. The error is visible on out_port, and on a20_gate when bit 1 differs, one clock after the busy flag drops. A corrupted delay counter or busy flag shows at the status address within the same poll window, as a busy bit that clears one cycle early or late. A wrongly latched output buffer or full flag is caught by the next status or data read after a 0xD0 command. Dropped writes during busy periods are exposed by following them with a data byte whose effect depends on whether the dropped command was taken.

// File: rtl/kbc_pkg.sv
package kbc_pkg;
  localparam logic [7:0] CMD_OUT_READ  = 8'hD0;
  localparam logic [7:0] CMD_OUT_WRITE = 8'hD1;
  localparam logic [7:0] CMD_KBD_OFF   = 8'hAD;
  localparam logic [7:0] CMD_KBD_ON    = 8'hAE;
  localparam logic [7:0] OUT_PORT_RST  = 8'hDD;
  localparam int         ST_OBF_BIT    = 0;
  localparam int         ST_IBF_BIT    = 1;
  localparam int         GATE_BIT      = 1;

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] value;
  } in_entry_t;
endpackage

// File: rtl/kbc_host_if.sv
module kbc_host_if
  import kbc_pkg::*;
#(
  parameter int         AW        = 8,
  parameter logic [7:0] CMD_ADDR  = 8'h64,
  parameter logic [7:0] DATA_ADDR = 8'h60
) (
  input  logic [AW-1:0] io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic          ibf,
  input  logic          obf,
  input  logic [7:0]    obuf,
  output logic          wr_accept,
  output logic          wr_is_cmd,
  output logic          rd_pop,
  output logic [7:0]    io_rdata
);
  logic hit_cmd;
  logic hit_dat;
  logic [7:0] status;

  always_comb begin
    hit_cmd = (io_addr == AW'(CMD_ADDR));
    hit_dat = (io_addr == AW'(DATA_ADDR));
    wr_accept = io_wr && (hit_cmd || hit_dat) && !ibf;
    wr_is_cmd = hit_cmd;
    rd_pop    = io_rd && hit_dat;
    status = 8'h00;
    status[ST_IBF_BIT] = ibf;
    status[ST_OBF_BIT] = obf;
    if (io_rd && hit_cmd)      io_rdata = status;
    else if (io_rd && hit_dat) io_rdata = obuf;
    else                       io_rdata = 8'h00;
  end
endmodule

// File: rtl/kbc_inbuf.sv
module kbc_inbuf
  import kbc_pkg::*;
#(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_accept,
  input  logic             wr_is_cmd,
  input  logic [7:0]       wdata,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic             ibf,
  output logic             proc_stb,
  output in_entry_t        proc_entry
);
  logic             ibf_q, ibf_n;
  logic [DLY_W-1:0] cnt_q, cnt_n;
  in_entry_t        ent_q;
  logic             ent_en;

  always_comb begin
    proc_stb = ibf_q && (cnt_q == '0);
    ibf_n  = ibf_q;
    cnt_n  = cnt_q;
    ent_en = 1'b0;
    if (proc_stb) begin
      ibf_n = 1'b0;
    end else if (ibf_q) begin
      cnt_n = cnt_q - 1'b1;
    end
    if (wr_accept) begin
      ibf_n  = 1'b1;
      cnt_n  = delay_cfg;
      ent_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ibf_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      ibf_q <= ibf_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_q <= '0;
    end else if (ent_en) begin
      ent_q <= '{is_cmd: wr_is_cmd, value: wdata};
    end
  end

  assign ibf        = ibf_q;
  assign proc_entry = ent_q;
endmodule

// File: rtl/kbc_cmd_engine.sv
module kbc_cmd_engine
  import kbc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       proc_stb,
  input  in_entry_t  proc_entry,
  input  logic       rd_pop,
  output logic [7:0] out_port,
  output logic       kbd_en,
  output logic       obf,
  output logic [7:0] obuf
);
  logic [7:0] outp_q, outp_n;
  logic       kbd_q, kbd_n;
  logic       obf_q, obf_n;
  logic [7:0] obuf_q, obuf_n;
  logic       pend_q, pend_n;

  always_comb begin
    outp_n = outp_q;
    kbd_n  = kbd_q;
    obf_n  = obf_q;
    obuf_n = obuf_q;
    pend_n = pend_q;
    if (rd_pop) obf_n = 1'b0;
    if (proc_stb) begin
      if (proc_entry.is_cmd) begin
        pend_n = 1'b0;
        unique case (proc_entry.value)
          CMD_OUT_READ: begin
            obuf_n = outp_q;
            obf_n  = 1'b1;
          end
          CMD_OUT_WRITE: pend_n = 1'b1;
          CMD_KBD_OFF:   kbd_n  = 1'b0;
          CMD_KBD_ON:    kbd_n  = 1'b1;
          default: ;
        endcase
      end else if (pend_q) begin
        outp_n = proc_entry.value;
        pend_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outp_q <= OUT_PORT_RST;
      kbd_q  <= 1'b1;
      obf_q  <= 1'b0;
      obuf_q <= 8'h00;
      pend_q <= 1'b0;
    end else begin
      outp_q <= outp_n;
      kbd_q  <= kbd_n;
      obf_q  <= obf_n;
      obuf_q <= obuf_n;
      pend_q <= pend_n;
    end
  end

  assign out_port = outp_q;
  assign kbd_en   = kbd_q;
  assign obf      = obf_q;
  assign obuf     = obuf_q;
endmodule

// File: rtl/kbc_cmd_port.sv
module kbc_cmd_port
  import kbc_pkg::*;
#(
  parameter int         AW         = 8,
  parameter int         DLY_W      = 8,
  parameter int         RST_STAGES = 2,
  parameter logic [7:0] CMD_ADDR   = 8'h64,
  parameter logic [7:0] DATA_ADDR  = 8'h60
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [7:0]       io_wdata,
  output logic [7:0]       io_rdata,
  input  logic [DLY_W-1:0] delay_cfg,
  output logic [7:0]       out_port,
  output logic             a20_gate,
  output logic             kbd_enable
);
  logic [RST_STAGES-1:0] rst_pipe;
  logic                  rst_sync_n;
  logic                  ibf_q;
  logic                  obf_q;
  logic [7:0]            obuf;
  logic                  wr_accept;
  logic                  wr_is_cmd;
  logic                  rd_pop;
  logic                  proc_stb;
  in_entry_t             proc_entry;

  generate
    if (RST_STAGES == 1) begin : g_rst1
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= 1'b1;
      end
    end else begin : g_rstn
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rst_pipe <= '0;
        else        rst_pipe <= {rst_pipe[RST_STAGES-2:0], 1'b1};
      end
    end
  endgenerate
  assign rst_sync_n = rst_pipe[RST_STAGES-1];

  kbc_host_if #(.AW(AW), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)) u_host (
    .io_addr  (io_addr),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .ibf      (ibf_q),
    .obf      (obf_q),
    .obuf     (obuf),
    .wr_accept(wr_accept),
    .wr_is_cmd(wr_is_cmd),
    .rd_pop   (rd_pop),
    .io_rdata (io_rdata)
  );

  kbc_inbuf #(.DLY_W(DLY_W)) u_inbuf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_accept (wr_accept),
    .wr_is_cmd (wr_is_cmd),
    .wdata     (io_wdata),
    .delay_cfg (delay_cfg),
    .ibf       (ibf_q),
    .proc_stb  (proc_stb),
    .proc_entry(proc_entry)
  );

  kbc_cmd_engine u_eng (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .proc_stb  (proc_stb),
    .proc_entry(proc_entry),
    .rd_pop    (rd_pop),
    .out_port  (out_port),
    .kbd_en    (kbd_enable),
    .obf       (obf_q),
    .obuf      (obuf)
  );

  assign a20_gate = out_port[GATE_BIT];
endmodule

// File: rtl/kbc_cmd_port_chk.sv
module kbc_cmd_port_chk #(
  parameter int         AW        = 8,
  parameter logic [7:0] CMD_ADDR  = 8'h64,
  parameter logic [7:0] DATA_ADDR = 8'h60
) (
  input logic          clk,
  input logic          rst_sync_n,
  input logic [AW-1:0] io_addr,
  input logic          io_wr,
  input logic          io_rd,
  input logic [7:0]    io_rdata,
  input logic          ibf,
  input logic          obf,
  input logic [7:0]    out_port,
  input logic          kbd_enable
);
  logic hit_cmd, hit_dat;
  assign hit_cmd = (io_addr == AW'(CMD_ADDR));
  assign hit_dat = (io_addr == AW'(DATA_ADDR));

  AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && hit_cmd) |-> (io_rdata[7:2] == 6'd0)); // R2
  AST_WRITE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr && (hit_cmd || hit_dat) && !ibf) |=> ibf); // R3
  AST_BUSY_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(ibf) |-> $past(io_wr)); // R3
  AST_OBF_RISES_ON_PROC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(obf) |-> $fell(ibf)); // R5
  AST_OBF_CLEARED_BY_READ: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && hit_dat && !ibf) |=> !obf); // R6
  AST_OUTPORT_MOVES_ON_PROC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(out_port) |-> $fell(ibf)); // R7
  AST_KBD_MOVES_ON_PROC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !$stable(kbd_enable) |-> $fell(ibf)); // R9
  AST_OTHER_ADDR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_rd && !hit_cmd && !hit_dat) |-> (io_rdata == 8'h00)); // R12
endmodule

bind kbc_cmd_port kbc_cmd_port_chk #(.AW(AW), .CMD_ADDR(CMD_ADDR), .DATA_ADDR(DATA_ADDR)) u_chk (
  .clk       (clk),
  .rst_sync_n(rst_sync_n),
  .io_addr   (io_addr),
  .io_wr     (io_wr),
  .io_rd     (io_rd),
  .io_rdata  (io_rdata),
  .ibf       (ibf_q),
  .obf       (obf_q),
  .out_port  (out_port),
  .kbd_enable(kbd_enable)
);

// File: tb/kbc_cmd_port_tb.sv
`timescale 1ns/1ps
module kbc_cmd_port_tb;
  localparam logic [7:0] PCMD = 8'h64;
  localparam logic [7:0] PDAT = 8'h60;

  logic       clk;
  logic       rst_n;
  logic [7:0] io_addr;
  logic       io_wr;
  logic       io_rd;
  logic [7:0] io_wdata;
  logic [7:0] io_rdata;
  logic [7:0] delay_cfg;
  logic [7:0] out_port;
  logic       a20_gate;
  logic       kbd_enable;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    logic [7:0] v;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  kbc_cmd_port u_dut (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .delay_cfg(delay_cfg),
    .out_port(out_port), .a20_gate(a20_gate), .kbd_enable(kbd_enable)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (io_rd && !done) begin
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL unexpected read: actual=%02h expected=none", io_rdata);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (io_rdata !== e.v) begin
          bad++;
          $display("FAIL %s: actual=%02h expected=%02h", e.tag, io_rdata, e.v);
        end
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(posedge clk); #2;
    io_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, logic [7:0] e, string tag);
    exp_t x;
    x.v = e; x.tag = tag;
    exp_q.push_back(x);
    io_addr = a; io_rd = 1'b1;
    @(posedge clk); #2;
    io_rd = 1'b0;
  endtask

  task automatic settle();
    step(int'(delay_cfg) + 1);
  endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] e);
    total++;
    if (act !== e) begin
      bad++;
      $display("FAIL %s: actual=%02h expected=%02h", tag, act, e);
    end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; io_addr = 8'h00; io_wr = 1'b0; io_rd = 1'b0;
    io_wdata = 8'h00; delay_cfg = 8'd3;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    step(4);

    // R1 / R2 reset state
    rd(PCMD, 8'h00, "R1 status after reset");
    chk("R1 out_port after reset", out_port, 8'hDD);
    chk("R1 a20_gate after reset", {7'd0, a20_gate}, 8'h00);
    chk("R1 kbd_enable after reset", {7'd0, kbd_enable}, 8'h01);

    // R3 + R11: unknown command, delay 3 -> busy for 4 cycles
    wr(PCMD, 8'h55);
    for (int i = 0; i < 4; i++) rd(PCMD, 8'h02, "R3 busy window D=3");
    rd(PCMD, 8'h00, "R3 busy cleared D=3 (R11 no obf)");
    chk("R11 out_port unchanged", out_port, 8'hDD);
    chk("R11 kbd_enable unchanged", {7'd0, kbd_enable}, 8'h01);

    // R3 with delay 0
    delay_cfg = 8'd0;
    wr(PCMD, 8'h55);
    rd(PCMD, 8'h02, "R3 busy window D=0");
    rd(PCMD, 8'h00, "R3 busy cleared D=0");
    delay_cfg = 8'd3;

    // R5 / R6 read output register
    wr(PCMD, 8'hD0); settle();
    rd(PCMD, 8'h01, "R5 obf set by D0");
    rd(PDAT, 8'hDD, "R6 data read returns output register");
    rd(PCMD, 8'h00, "R6 obf cleared by data read");

    // R7 write 0xDF -> gate on
    wr(PCMD, 8'hD1); settle();
    wr(PDAT, 8'hDF); settle();
    chk("R7 out_port after D1/DF", out_port, 8'hDF);
    chk("R7 a20_gate on", {7'd0, a20_gate}, 8'h01);
    wr(PCMD, 8'hD0); settle();
    rd(PDAT, 8'hDF, "R5 readback after write");

    // R7 gate off then read-modify-write
    wr(PCMD, 8'hD1); settle();
    wr(PDAT, 8'hDD); settle();
    chk("R7 a20_gate off", {7'd0, a20_gate}, 8'h00);
    wr(PCMD, 8'hD1); settle();
    wr(PDAT, 8'hDD | 8'h02); settle();
    chk("R7 out_port OR 0x02", out_port, 8'hDF);

    // R8 data without pending write
    wr(PDAT, 8'h00); settle();
    chk("R8 stray data ignored", out_port, 8'hDF);

    // R10 + R9: D1 then AD disarms; AD clears enable
    wr(PCMD, 8'hD1); settle();
    wr(PCMD, 8'hAD); settle();
    chk("R9 kbd_enable cleared by AD", {7'd0, kbd_enable}, 8'h00);
    wr(PDAT, 8'h00); settle();
    chk("R10 pending disarmed by other command", out_port, 8'hDF);
    wr(PCMD, 8'hAE); settle();
    chk("R9 kbd_enable set by AE", {7'd0, kbd_enable}, 8'h01);

    // R4: command written while busy is dropped
    wr(PCMD, 8'hD0);
    wr(PCMD, 8'hD1);
    settle();
    rd(PDAT, 8'hDF, "R4 first command still processed");
    wr(PDAT, 8'h00); settle();
    chk("R4 busy write dropped", out_port, 8'hDF);

    // R12 other addresses ignored
    wr(8'h70, 8'hD1);
    rd(PCMD, 8'h00, "R12 write elsewhere sets no busy");
    rd(8'h70, 8'h00, "R12 read elsewhere returns 0");
    wr(PDAT, 8'h00); settle();
    chk("R12 write elsewhere arms nothing", out_port, 8'hDF);

    step(2);
    total++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard drain: actual=%0d expected=0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule